// File: doc/BRIEF.md
# Phase-Accumulator Trigger Rate Generator

This block produces a programmable trigger rate from a single system clock. A wide phase register advances by a programmable step every cycle, and each time its top bit turns on, a one-cycle trigger strobe is issued. The trigger rate is therefore the clock rate times the step divided by two to the accumulator width. No waveform table is involved. The trigger can only fall on a clock edge, so each strobe also carries a small delay code. That code is taken from the phase bits just below the top bit and tells an external analog fine-delay stage how far to push the edge. This moves the edge to within a fraction of a clock of its ideal position.

An integer post-divider passes only every Dth accumulator trigger, which reaches very long periods. Settings are held in two banks, each with a step and a divisor. Software writes the idle bank and then asks for a swap. The swap waits for the next trigger the block actually emits, so triggering never stops and no period mixes old and new settings.

Top module: `trig_gen`

## Requirements
- R1: The 48-bit phase register adds the active step every clock. trigValid is high for exactly one cycle, in the cycle after the addition that turned bit 47 from 0 to 1, so the rate is Fclk x step / 2^48.
- R2: With each trigger, trigDelay gives the bitwise inverse of bits 46 down to 43 of the phase value produced by that addition. Between triggers trigDelay keeps its value.
- R3: A step of 2^47 (half the clock rate) triggers on every second cycle. Two triggers never fall in adjacent cycles.
- R4: With a divisor D of 2 or more, only every Dth accumulator trigger is emitted, counting from the last bank swap or reset. A divisor of 0 or 1 emits every trigger.
- R5: A write with cfgWr loads the step and divisor into the bank that is not active. It has no effect on the outputs until a swap.
- R6: A swapReq pulse is held pending. It takes effect in the cycle of the next emitted trigger: activeBank flips in the cycle trigValid shows, the next addition uses the new step, and the divider count restarts. The phase register is not cleared.
- R7: While the active step is zero, the phase register holds and no trigger is issued. A pending swap then takes effect on the following clock without waiting for a trigger.
- R8: A synchronous reset clears the phase register, the divider count, both banks, the pending swap and the bank select (activeBank 0). trigValid is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWr | input | 1 | Load cfgTuning and cfgDivisor into the idle bank |
| cfgTuning | input | 48 | Phase step for the idle bank |
| cfgDivisor | input | 16 | Post-divider ratio for the idle bank |
| swapReq | input | 1 | Request to make the idle bank active |
| trigValid | output | 1 | One-cycle trigger strobe |
| trigDelay | output | 4 | Fine-delay code for the current trigger |
| activeBank | output | 1 | Index of the bank in use |

## Verification
The hardest situation to reach is a swap that lands on a divided trigger while the phase keeps running. The pending request must wait through several suppressed accumulator crossings, and then flip the bank exactly on the emitted one. The directed stimulus reaches it by running with a divisor of 3, issuing swapReq in the middle of a divided period, and watching every later cycle. A cycle-by-cycle expectation built from the requirements tracks phase, divider count, pending state and bank index. The zero-step escape path is reached by swapping to a bank loaded with step 0 and then swapping back out.

// File: rtl/trig_gen_pkg.sv
package trig_gen_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic bankSel;
    logic swapNow;
  } ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic wrapEdge;
    logic divTerm;
    logic activeZero;
  } stat_t;
endpackage

// File: rtl/trig_gen_ctrl.sv
module trig_gen_ctrl
  import trig_gen_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  swapReq,
  input  stat_t stat,
  output ctrl_t ctrl
);
  logic bankSel;
  logic swapPending;
  logic swapNow;

  // a swap lands on an emitted trigger, or at once when the phase is frozen
  assign swapNow = swapPending && (stat.activeZero || (stat.wrapEdge && stat.divTerm));

  always_ff @(posedge clk) begin
    if (rst) begin
      bankSel     <= 1'b0;
      swapPending <= 1'b0;
    end else begin
      bankSel     <= bankSel ^ swapNow;
      swapPending <= swapReq | (swapPending & ~swapNow);
    end
  end

  assign ctrl.bankSel = bankSel;
  assign ctrl.swapNow = swapNow;
endmodule

// File: rtl/trig_gen_dp.sv
module trig_gen_dp
  import trig_gen_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int DLY_W = 4,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWr,
  input  logic [ACC_W-1:0] cfgTuning,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  ctrl_t            ctrl,
  output stat_t            stat,
  output logic             trigValid,
  output logic [DLY_W-1:0] trigDelay
);
  localparam int MSB    = ACC_W - 1;
  localparam int BANKS  = 2;

  logic [ACC_W-1:0] tuneArr [BANKS];
  logic [DIV_W-1:0] divArr  [BANKS];

  // one register set per bank; only the idle one accepts writes
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ACC_W-1:0] tuneQ;
    logic [DIV_W-1:0] divQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        tuneQ <= '0;
        divQ  <= '0;
      end else if (cfgWr && (ctrl.bankSel != 1'(b))) begin
        tuneQ <= cfgTuning;
        divQ  <= cfgDivisor;
      end
    end
    assign tuneArr[b] = tuneQ;
    assign divArr[b]  = divQ;
  end

  logic [ACC_W-1:0] phase;
  logic [ACC_W-1:0] phaseNext;
  logic [ACC_W-1:0] activeTune;
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] divCnt;
  logic             wrapEdge;
  logic             divPass;
  logic             divTerm;
  logic             emit;

  assign activeTune = tuneArr[ctrl.bankSel];
  assign activeDiv  = divArr[ctrl.bankSel];
  assign phaseNext  = phase + activeTune;
  assign wrapEdge   = ~phase[MSB] & phaseNext[MSB];
  assign divPass    = (activeDiv <= DIV_W'(1));
  assign divTerm    = divPass || (divCnt == activeDiv - DIV_W'(1));
  assign emit       = wrapEdge && divTerm;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      divCnt    <= '0;
      trigValid <= 1'b0;
      trigDelay <= '0;
    end else begin
      phase     <= phaseNext;
      trigValid <= emit;
      if (emit) trigDelay <= ~phaseNext[MSB-1 -: DLY_W];
      if (ctrl.swapNow)  divCnt <= '0;
      else if (wrapEdge) divCnt <= divTerm ? '0 : divCnt + DIV_W'(1);
    end
  end

  assign stat.wrapEdge   = wrapEdge;
  assign stat.divTerm    = divTerm;
  assign stat.activeZero = (activeTune == '0);
endmodule

// File: rtl/trig_gen.sv
module trig_gen
  import trig_gen_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int DLY_W = 4,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWr,
  input  logic [ACC_W-1:0] cfgTuning,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic             swapReq,
  output logic             trigValid,
  output logic [DLY_W-1:0] trigDelay,
  output logic             activeBank
);
  ctrl_t ctrlW;
  stat_t statW;

  trig_gen_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .swapReq(swapReq),
    .stat   (statW),
    .ctrl   (ctrlW)
  );

  trig_gen_dp #(.ACC_W(ACC_W), .DLY_W(DLY_W), .DIV_W(DIV_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .cfgWr     (cfgWr),
    .cfgTuning (cfgTuning),
    .cfgDivisor(cfgDivisor),
    .ctrl      (ctrlW),
    .stat      (statW),
    .trigValid (trigValid),
    .trigDelay (trigDelay)
  );

  assign activeBank = ctrlW.bankSel;
endmodule

// File: rtl/trig_gen_chk.sv
module trig_gen_chk (
  input logic clk,
  input logic rst,
  input logic trigValid,
  input logic activeBank,
  input logic activeZero
);
  // R3: a crossing leaves the top bit set, so no trigger can follow at once
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    trigValid |=> !trigValid);

  // R8: the first cycle out of reset shows cleared outputs
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!trigValid && !activeBank));

  // R7: a frozen phase never yields a trigger
  a_r7_zero_hold: assert property (@(posedge clk) disable iff (rst)
    activeZero |=> !trigValid);

  // R6: with a running phase the bank only flips together with a trigger
  a_r6_flip_on_trigger: assert property (@(posedge clk) disable iff (rst)
    ((activeBank != $past(activeBank)) && !$past(activeZero)) |-> trigValid);
endmodule

bind trig_gen trig_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .trigValid (trigValid),
  .activeBank(activeBank),
  .activeZero(statW.activeZero)
);

// File: tb/trig_gen_tb.sv
`timescale 1ns/1ps
module trig_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWr = 1'b0;
  logic [47:0] cfgTuning = '0;
  logic [15:0] cfgDivisor = '0;
  logic        swapReq = 1'b0;
  logic        trigValid;
  logic [3:0]  trigDelay;
  logic        activeBank;

  int checks = 0;
  int errors = 0;
  int trigSeen = 0;

  // expectation state built from the requirements
  logic [47:0] mAcc;
  logic [47:0] mT [2];
  logic [15:0] mD [2];
  logic [15:0] mCnt;
  logic        mSel;
  logic        mPend;
  logic [3:0]  mCode;

  always #2.5 clk = ~clk;

  trig_gen u_dut (
    .clk(clk), .rst(rst), .cfgWr(cfgWr), .cfgTuning(cfgTuning),
    .cfgDivisor(cfgDivisor), .swapReq(swapReq), .trigValid(trigValid),
    .trigDelay(trigDelay), .activeBank(activeBank)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mAcc = '0; mCnt = '0; mSel = 1'b0; mPend = 1'b0; mCode = '0;
    mT[0] = '0; mT[1] = '0; mD[0] = '0; mD[1] = '0;
  endtask

  // one clock: drive at negedge, advance expectation at posedge, compare at next negedge
  task automatic step(input bit wr, input logic [47:0] t, input logic [15:0] d,
                      input bit sw, input string tag);
    logic [47:0] nxt;
    logic        edgeM, termM, swapM, expV;
    cfgWr = wr; cfgTuning = t; cfgDivisor = d; swapReq = sw;
    @(posedge clk);
    nxt   = mAcc + mT[mSel];
    edgeM = !mAcc[47] && nxt[47];
    termM = (mD[mSel] <= 16'd1) || (mCnt == mD[mSel] - 16'd1);
    swapM = mPend && ((edgeM && termM) || (mT[mSel] == '0));
    expV  = edgeM && termM;
    if (expV) mCode = ~nxt[46:43];
    mAcc = nxt;
    if (swapM) mCnt = '0;
    else if (edgeM) mCnt = termM ? 16'd0 : mCnt + 16'd1;
    if (wr) begin mT[!mSel] = t; mD[!mSel] = d; end
    if (swapM) mSel = ~mSel;
    mPend = sw | (mPend & !swapM);
    @(negedge clk);
    cfgWr = 1'b0; swapReq = 1'b0;
    check(trigValid == expV, tag, "trigValid", trigValid, expV);
    check(trigDelay == mCode, "R2", "trigDelay", trigDelay, mCode);
    check(activeBank == mSel, tag, "activeBank", activeBank, mSel);
    if (trigValid) trigSeen++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic load_swap(input logic [47:0] t, input logic [15:0] d, input string tag);
    step(1'b1, t, d, 1'b0, tag);
    step(1'b0, '0, '0, 1'b1, tag);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_reset();
    check(trigValid == 1'b0, "R8", "trigValid after reset", trigValid, 0);
    check(activeBank == 1'b0, "R8", "activeBank after reset", activeBank, 0);
    idle(10, "R7");
  endtask

  task automatic t_basic();
    load_swap(48'h2000_0000_0000, 16'd0, "R7");
    idle(8, "R1");
    trigSeen = 0;
    idle(64, "R1");
    check(trigSeen == 8, "R1", "triggers in 64 cycles at step 2^45", trigSeen, 8);
  endtask

  task automatic t_fraction();
    load_swap(48'h1555_5555_5555, 16'd1, "R6");
    idle(90, "R2");
  endtask

  task automatic t_nyquist();
    load_swap(48'h8000_0000_0000, 16'd0, "R6");
    idle(6, "R3");
    trigSeen = 0;
    idle(20, "R3");
    check(trigSeen == 10, "R3", "triggers in 20 cycles at half rate", trigSeen, 10);
  endtask

  task automatic t_divider();
    load_swap(48'h2000_0000_0000, 16'd3, "R6");
    idle(120, "R4");
    load_swap(48'h2100_0000_0000, 16'd1, "R6");
    idle(60, "R4");
    load_swap(48'h1F00_0000_0000, 16'd0, "R6");
    idle(60, "R4");
  endtask

  task automatic t_idle_write();
    step(1'b1, 48'h7FFF_0000_0001, 16'd5, 1'b0, "R5");
    idle(40, "R5");
    step(1'b1, 48'h0000_0000_0000, 16'd9, 1'b0, "R5");
    idle(40, "R5");
  endtask

  task automatic t_live_swap();
    load_swap(48'h2000_0000_0000, 16'd3, "R6");
    idle(30, "R6");
    step(1'b1, 48'h3333_3333_3333, 16'd2, 1'b0, "R6");
    idle(5, "R6");
    step(1'b0, '0, '0, 1'b1, "R6");
    idle(60, "R6");
  endtask

  task automatic t_zero();
    load_swap(48'h0, 16'd0, "R7");
    idle(40, "R7");
    trigSeen = 0;
    idle(30, "R7");
    check(trigSeen == 0, "R7", "triggers with zero step", trigSeen, 0);
    load_swap(48'h0ABC_DEF0_1234, 16'd0, "R7");
    idle(80, "R7");
  endtask

  task automatic t_reset_mid();
    load_swap(48'h2000_0000_0000, 16'd2, "R6");
    idle(25, "R8");
    t_reset();
    trigSeen = 0;
    idle(20, "R8");
    check(trigSeen == 0, "R8", "triggers after reset with cleared banks", trigSeen, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    t_reset();
    t_basic();
    t_fraction();
    t_nyquist();
    t_divider();
    t_idle_write();
    t_live_swap();
    t_zero();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule